// File: doc/BRIEF.md
# Nibble-Addressed Control Bus Master

This block sits between a processor and a small parallel control bus. The processor asks it to write a 4-bit value into one of the remote latches on the bus, or to read a 4-bit value from one of the remote buffers. The bus carries a 4-bit address and a 4-bit data nibble. A set of bank-enable strobes, three by default, gates the remote address decoders. Each enable selects its own bank of 16 nibble locations, so one address names as many separate latches as there are enables, and the default configuration reaches 192 control bits.

Each transfer follows a fixed sequence. The address and data are set up first. The chosen enable is then pulsed for one cycle. Address and data are held for one more cycle, and a response is returned. During a read the master releases the data lines and captures the returned nibble one cycle after the enable pulse. A request whose bank selection is not exactly one-hot is refused at once with an error response, and it causes no bus activity.

The same block also takes a periodic timing reference, such as a 100 Hz square wave. Each rising edge raises an interrupt flag. When the processor acknowledges the flag, a tick counter advances. A tick that arrives while the flag is still unacknowledged sets a sticky overrun bit.

Top module: `ctlbus_master`

## Requirements
- R1: While reset is low, and in the first cycle after reset, bus_en is 0, bus_data_oe is 0, req_ready is 1, rsp_valid is 0, rsp_err is 0, irq_pending is 0, irq_overrun is 0 and tick_count is 0.
- R2: A request is accepted at a clock edge where req_valid and req_ready are both 1 and req_sel has exactly one bit set; call that edge 0. After edge 0, req_ready is 0. bus_en equals req_sel only in the cycle between edges 1 and 2, and it is 0 otherwise. rsp_valid is 1, with rsp_err 0, only in the cycle between edges 3 and 4. req_ready is 1 again from edge 3.
- R3: At most one bit of bus_en is ever 1.
- R4: From edge 1 to edge 3 of a transaction, bus_addr equals the request address. During a write over the same span, bus_data_out equals the request data. Neither changes while an enable is high, nor in the cycle after it.
- R5: A write drives bus_data_oe to 1 from edge 1 to edge 3. A read keeps bus_data_oe at 0 throughout. For a read, rsp_rdata is the value on bus_data_in at edge 3, which is one cycle after the enable cycle. For a write, rsp_rdata is 0.
- R6: Bank b is the req_sel bit index. A read of bank b at address a returns the nibble last written to bank b at address a, or 0 if nothing was written there. Banks do not alias one another.
- R7: A request at an edge where req_ready is 1 and req_sel has zero bits set, or two or more, sets rsp_valid and rsp_err to 1 for the one cycle after that edge. req_ready stays 1 and bus_en stays 0.
- R8: While req_ready is 0, req_valid is ignored. No extra bus transaction and no extra response result from it.
- R9: A rising edge on tick_in, meaning tick_in is 1 at a clock edge where it was 0 at the previous edge, sets irq_pending after that edge. irq_pending then stays 1 until it is acknowledged. A level held high counts as one tick.
- R10: An edge with irq_ack 1 and irq_pending 1 advances tick_count by one, modulo 2^CNT_W. The same edge clears irq_pending unless a new tick arrives on it. irq_ack while irq_pending is 0 changes nothing.
- R11: A tick that arrives while irq_pending is 1 and irq_ack is 0 sets irq_overrun, which then stays 1 until reset. A tick that coincides with an acknowledge advances the count, leaves irq_pending at 1 and does not set irq_overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | N_EN | Bank enable selection, one-hot required |
| req_addr | input | ADDR_W | Latch or buffer address |
| req_wdata | input | DATA_W | Write nibble |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response is a rejection |
| rsp_rdata | output | DATA_W | Read nibble |
| bus_en | output | N_EN | Bank enable strobes |
| bus_addr | output | ADDR_W | Bus address lines |
| bus_data_out | output | DATA_W | Data driven by master |
| bus_data_oe | output | 1 | Master drives data lines |
| bus_data_in | input | DATA_W | Data lines as seen by master |
| tick_in | input | 1 | Periodic timing reference |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_pending | output | 1 | Timer interrupt pending |
| irq_overrun | output | 1 | Sticky missed-tick flag |
| tick_count | output | CNT_W | Acknowledged tick count |

## Verification
The edge that accepts a request is counted as edge 0. From there the enable strobe is due between edges 1 and 2, the read data is captured at edge 3, and the response is due between edges 3 and 4. A rejection answers one edge after the request. Timer flags and the counter change one edge after the tick or acknowledge that causes them. The bench keeps a behavioural model that advances on each rising edge from the inputs it drove at the previous falling edge. At every falling edge the model's expected outputs are compared with the ports, so each result is checked in the exact cycle it is due.

// File: rtl/ctlbus_pkg.sv
`timescale 1ns/1ps
package ctlbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;

  // number of set bits in a selection vector, zero-extended to 32 bits
  function automatic int unsigned bit_total(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/ctlbus_req_check.sv
`timescale 1ns/1ps
module ctlbus_req_check #(
  parameter int N_EN = 3
) (
  input  logic [N_EN-1:0] sel,
  output logic            sel_ok
);
  import ctlbus_pkg::*;

  always_comb sel_ok = (bit_total(32'(sel)) == 1);

endmodule

// File: rtl/ctlbus_seq.sv
`timescale 1ns/1ps
module ctlbus_seq #(
  parameter int N_EN   = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [N_EN-1:0]   start_sel,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              idle,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [N_EN-1:0]   bus_en,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_data_in
);
  import ctlbus_pkg::*;

  seq_state_t        state_q;
  logic              wr_q;
  logic [N_EN-1:0]   sel_q;
  logic [N_EN-1:0]   en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              oe_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  // named event: the cycle in which the returned nibble is captured
  logic capture_evt;
  assign capture_evt = (state_q == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            wr_q    <= start_write;
            sel_q   <= start_sel;
            addr_q  <= start_addr;
            data_q  <= start_wdata;
            oe_q    <= start_write;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP:  state_q <= ST_STROBE;
        ST_STROBE: state_q <= ST_HOLD;
        ST_HOLD: begin
          rdata_q <= wr_q ? '0 : bus_data_in;
          oe_q    <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // one strobe register per bank enable
  for (genvar g = 0; g < N_EN; g++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (!rst_n) en_q[g] <= 1'b0;
      else        en_q[g] <= (state_q == ST_SETUP) && sel_q[g];
    end
  end

  assign idle         = (state_q == ST_IDLE);
  assign done         = done_q;
  assign rdata        = rdata_q;
  assign bus_en       = en_q;
  assign bus_addr     = addr_q;
  assign bus_data_out = data_q;
  assign bus_data_oe  = oe_q;

  // R3: never more than one bank strobed
  a_r3_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_en));

  // R2: the strobe lasts exactly one cycle
  a_r2_enable_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en != '0) |=> (bus_en == '0));

  // R4: address and data settled before the strobe and held after it
  a_r4_setup_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en != '0) |-> ($stable(bus_addr) && $stable(bus_data_out)));
  a_r4_hold_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en != '0) |=> ($stable(bus_addr) && $stable(bus_data_out) && $stable(bus_data_oe)));

  // R5: a read leaves the data lines released while the bank answers
  a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_en != '0) && !wr_q) |-> !bus_data_oe);

  // R2: the response follows the capture cycle
  a_r2_done_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> done);

endmodule

// File: rtl/ctlbus_tick.sv
`timescale 1ns/1ps
module ctlbus_tick #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             irq_ack,
  output logic             irq_pending,
  output logic             irq_overrun,
  output logic [CNT_W-1:0] tick_count
);

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  logic             prev_q;
  logic             pend_q;
  logic             ovr_q;
  logic [CNT_W-1:0] cnt_q;

  // named events
  logic tick_rise;
  logic ack_taken;
  logic miss_evt;
  assign tick_rise = tick_in && !prev_q;
  assign ack_taken = irq_ack && pend_q;
  assign miss_evt  = tick_rise && pend_q && !irq_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= tick_in;
      if (ack_taken) cnt_q <= count_step(cnt_q);
      if (tick_rise)      pend_q <= 1'b1;
      else if (ack_taken) pend_q <= 1'b0;
      if (miss_evt) ovr_q <= 1'b1;
    end
  end

  assign irq_pending = pend_q;
  assign irq_overrun = ovr_q;
  assign tick_count  = cnt_q;

  // R9: pending stays until acknowledged
  a_r9_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_ack) |=> irq_pending);

  // R9: a rising tick always leaves the flag set
  a_r9_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> irq_pending);

  // R10: count moves only on an accepted acknowledge
  a_r10_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ack && irq_pending) |=> $stable(tick_count));

  // R11: overrun is sticky
  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_overrun |=> irq_overrun);

endmodule

// File: rtl/ctlbus_master.sv
`timescale 1ns/1ps
module ctlbus_master #(
  parameter int N_EN   = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [N_EN-1:0]   req_sel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [N_EN-1:0]   bus_en,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_data_in,
  input  logic              tick_in,
  input  logic              irq_ack,
  output logic              irq_pending,
  output logic              irq_overrun,
  output logic [CNT_W-1:0]  tick_count
);

  logic sel_ok;
  logic seq_idle;
  logic seq_done;
  logic err_q;

  // named events
  logic take_req;
  logic reject_req;
  assign take_req   = req_valid && seq_idle && sel_ok;
  assign reject_req = req_valid && seq_idle && !sel_ok;

  ctlbus_req_check #(.N_EN(N_EN)) i_check (
    .sel    (req_sel),
    .sel_ok (sel_ok)
  );

  ctlbus_seq #(.N_EN(N_EN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (take_req),
    .start_write  (req_write),
    .start_sel    (req_sel),
    .start_addr   (req_addr),
    .start_wdata  (req_wdata),
    .idle         (seq_idle),
    .done         (seq_done),
    .rdata        (rsp_rdata),
    .bus_en       (bus_en),
    .bus_addr     (bus_addr),
    .bus_data_out (bus_data_out),
    .bus_data_oe  (bus_data_oe),
    .bus_data_in  (bus_data_in)
  );

  ctlbus_tick #(.CNT_W(CNT_W)) i_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_in     (tick_in),
    .irq_ack     (irq_ack),
    .irq_pending (irq_pending),
    .irq_overrun (irq_overrun),
    .tick_count  (tick_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= reject_req;
  end

  assign req_ready = seq_idle;
  assign rsp_valid = err_q || seq_done;
  assign rsp_err   = err_q;

  // R7: a rejection leaves the bus quiet and the master idle
  a_r7_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> ((bus_en == '0) && req_ready));

  // R7: a rejected request is answered on the next cycle
  a_r7_reject_answer: assert property (@(posedge clk) disable iff (!rst_n)
    reject_req |=> (rsp_valid && rsp_err));

  // R8: a request while busy starts nothing
  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready) |=> !rsp_err);

endmodule

// File: tb/test_ctlbus_master.sv
`timescale 1ns/1ps
module remote_banks #(
  parameter int N_EN = 3
) (
  input  logic            clk,
  input  logic [N_EN-1:0] bus_en,
  input  logic [3:0]      bus_addr,
  input  logic [3:0]      bus_data_out,
  input  logic            bus_data_oe,
  output logic [3:0]      rd_nib
);
  logic [3:0] mem [N_EN][16];
  initial begin
    for (int b = 0; b < N_EN; b++)
      for (int a = 0; a < 16; a++) mem[b][a] = 4'h0;
    rd_nib = 4'h0;
  end
  always @(posedge clk) begin
    for (int b = 0; b < N_EN; b++) begin
      if (bus_en[b]) begin
        if (bus_data_oe) mem[b][bus_addr] <= bus_data_out;
        else             rd_nib <= mem[b][bus_addr];
      end
    end
  end
endmodule

module test_ctlbus_master;
  localparam int N_EN = 3;
  localparam int CW   = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [N_EN-1:0] req_sel = '0;
  logic [3:0] req_addr = '0, req_wdata = '0;
  logic tick_in = 1'b0, irq_ack = 1'b0;
  logic req_ready, rsp_valid, rsp_err, bus_data_oe, irq_pending, irq_overrun;
  logic [3:0] rsp_rdata, bus_addr, bus_data_out, rd_nib, bus_data_in;
  logic [N_EN-1:0] bus_en;
  logic [CW-1:0] tick_count;

  assign bus_data_in = bus_data_oe ? bus_data_out : rd_nib;

  ctlbus_master #(.N_EN(N_EN), .ADDR_W(4), .DATA_W(4), .CNT_W(CW)) i_ctlbus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_en(bus_en), .bus_addr(bus_addr),
    .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .bus_data_in(bus_data_in), .tick_in(tick_in), .irq_ack(irq_ack),
    .irq_pending(irq_pending), .irq_overrun(irq_overrun), .tick_count(tick_count)
  );

  remote_banks #(.N_EN(N_EN)) i_banks (
    .clk(clk), .bus_en(bus_en), .bus_addr(bus_addr),
    .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe), .rd_nib(rd_nib)
  );

  int vecs = 0;
  int miss = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_phase = 0;
  int m_en = 0, m_ready = 1, m_rvalid = 0, m_rerr = 0, m_rdata = 0, m_rpend = 0;
  int m_pend = 0, m_ovr = 0, m_cnt = 0, m_prev = 0;
  int c_wr = 0, c_sel = 0, c_bank = 0, c_addr = 0, c_data = 0;
  int shadow [N_EN][16];
  initial for (int b = 0; b < N_EN; b++) for (int a = 0; a < 16; a++) shadow[b][a] = 0;

  function automatic int bank_of(input int s);
    for (int i = 0; i < N_EN; i++) if (s == (1 << i)) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_en = 0; m_ready = 1; m_rvalid = 0; m_rerr = 0;
      m_pend = 0; m_ovr = 0; m_cnt = 0; m_prev = 0;
    end else begin
      int rise;
      m_rvalid = 0; m_rerr = 0;
      case (m_phase)
        0: if (req_valid) begin
             if (bank_of(int'(req_sel)) < 0) begin m_rvalid = 1; m_rerr = 1; end
             else begin
               c_wr = req_write; c_sel = req_sel; c_bank = bank_of(int'(req_sel));
               c_addr = req_addr; c_data = req_wdata; m_phase = 1;
             end
           end
        1: begin m_en = c_sel; m_phase = 2; end
        2: begin
             m_en = 0;
             if (c_wr) shadow[c_bank][c_addr] = c_data;
             else      m_rpend = shadow[c_bank][c_addr];
             m_phase = 3;
           end
        default: begin m_rvalid = 1; m_rdata = c_wr ? 0 : m_rpend; m_phase = 0; end
      endcase
      m_ready = (m_phase == 0);
      rise = tick_in && !m_prev;
      m_prev = tick_in;
      if (rise && m_pend && !irq_ack) m_ovr = 1;
      if (irq_ack && m_pend) m_cnt = (m_cnt + 1) % (1 << CW);
      if (rise) m_pend = 1;
      else if (irq_ack && m_pend) m_pend = 0;
    end
  end

  bit compare_on = 1'b0;
  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      chk("R2", "bus_en", int'(bus_en), m_en);
      chk("R3", "single enable", int'($countones(bus_en) <= 1), 1);
      chk("R8", "req_ready", int'(req_ready), m_ready);
      chk("R2", "rsp_valid", int'(rsp_valid), m_rvalid);
      chk("R7", "rsp_err", int'(rsp_err), m_rerr);
      if (m_rvalid && !m_rerr) chk("R6", "rsp_rdata", int'(rsp_rdata), m_rdata);
      if (m_phase != 0) begin
        chk("R4", "bus_addr", int'(bus_addr), c_addr);
        chk("R5", "bus_data_oe", int'(bus_data_oe), c_wr);
        if (c_wr) chk("R4", "bus_data_out", int'(bus_data_out), c_data);
      end else chk("R5", "bus_data_oe idle", int'(bus_data_oe), 0);
      chk("R9", "irq_pending", int'(irq_pending), m_pend);
      chk("R11", "irq_overrun", int'(irq_overrun), m_ovr);
      chk("R10", "tick_count", int'(tick_count), m_cnt);
    end
  end

  task automatic issue(input bit wr, input logic [N_EN-1:0] sel, input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic tick_pulse(input int high_cycles);
    @(negedge clk); tick_in = 1'b1;
    repeat (high_cycles) @(negedge clk);
    tick_in = 1'b0;
  endtask

  task automatic ack_once();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "bus_en", int'(bus_en), 0);
    chk("R1", "bus_data_oe", int'(bus_data_oe), 0);
    chk("R1", "req_ready", int'(req_ready), 1);
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "rsp_err", int'(rsp_err), 0);
    chk("R1", "irq_pending", int'(irq_pending), 0);
    chk("R1", "irq_overrun", int'(irq_overrun), 0);
    chk("R1", "tick_count", int'(tick_count), 0);
    compare_on = 1'b1;

    // R2 R4 R6: same address in every bank, plus address extremes
    issue(1'b1, 3'b001, 4'h5, 4'hA);
    issue(1'b1, 3'b010, 4'h5, 4'h3);
    issue(1'b1, 3'b100, 4'h5, 4'hC);
    issue(1'b1, 3'b001, 4'h0, 4'hF);
    issue(1'b1, 3'b100, 4'hF, 4'h1);
    issue(1'b0, 3'b001, 4'h5, 4'h0);
    issue(1'b0, 3'b010, 4'h5, 4'h0);
    issue(1'b0, 3'b100, 4'h5, 4'h0);
    issue(1'b0, 3'b001, 4'h0, 4'h0);
    issue(1'b0, 3'b100, 4'hF, 4'h0);
    issue(1'b0, 3'b010, 4'h9, 4'h0);   // R6 never written reads 0
    // R7 rejected selections
    issue(1'b1, 3'b000, 4'h2, 4'h7);
    issue(1'b1, 3'b011, 4'h2, 4'h7);
    issue(1'b0, 3'b111, 4'h2, 4'h7);
    issue(1'b0, 3'b010, 4'h2, 4'h0);
    // R8 requests while busy are dropped
    issue(1'b1, 3'b010, 4'h6, 4'h4);
    req_valid = 1'b1; req_write = 1'b1; req_sel = 3'b001; req_addr = 4'h6; req_wdata = 4'hE;
    @(negedge clk); @(negedge clk);
    req_valid = 1'b0;
    issue(1'b0, 3'b001, 4'h6, 4'h0);
    issue(1'b0, 3'b010, 4'h6, 4'h0);
    // back-to-back reads
    for (int i = 0; i < 16; i++) issue(1'b0, 3'b100, 4'(i), 4'h0);

    // R9 long high level is one tick; R10 ack counts
    repeat (3) @(negedge clk);
    tick_pulse(5);
    repeat (3) @(negedge clk);
    ack_once();
    ack_once();                        // R10 ack without pending
    // R11 tick coinciding with ack
    tick_pulse(1);
    @(negedge clk); tick_in = 1'b1; irq_ack = 1'b1;
    @(negedge clk); tick_in = 1'b0; irq_ack = 1'b0;
    ack_once();
    // R11 missed tick sets sticky overrun
    tick_pulse(1);
    @(negedge clk);
    tick_pulse(1);
    ack_once();
    repeat (3) @(negedge clk);
    // R10 counter wrap
    for (int i = 0; i < 260; i++) begin
      tick_pulse(1);
      ack_once();
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule